// File: doc/BRIEF.md
# Vector Increment by Pattern Count

This block adds one shared value to every lane of a vector register. The caller supplies a vector operand, a lane size (16, 32 or 64 bits), a 5-bit pattern code and a 4-bit multiplier field. From the pattern code and the number of lanes the vector holds at that lane size, the block derives an element count. Multiplying that count by the multiplier gives the addend, and the addend is added to every lane. Lanes wrap on their own and never carry into a neighbour.

The vector length is the parameter `VLEN`: a multiple of 128 bits, at most 2048. The operation is accepted with a valid/ready handshake. The result is held in an output register under a second valid/ready pair, so one operation can be accepted in the same cycle as the previous result drains. Pattern codes that name no rule give a count of zero, so the operand comes back unchanged and no error is flagged.

Top module: `vinc_top`

## Requirements
- R1: The lane count is VLEN divided by the lane size. esize_i code 0 selects 16-bit lanes, 1 selects 32-bit lanes, and 2 or 3 select 64-bit lanes.
- R2: The multiplier applied to the count is mult_i plus one, a value from 1 to 16.
- R3: Pattern 5'b00000 gives a count equal to the largest power of two that does not exceed the lane count.
- R4: Patterns 5'b00001 to 5'b01000 ask for a fixed count of 1 to 8. Patterns 5'b01001 to 5'b01101 ask for 16, 32, 64, 128 and 256 in that order. A requested count larger than the lane count gives zero.
- R5: Pattern 5'b11111 gives the full lane count. Pattern 5'b11101 gives the largest multiple of four that does not exceed the lane count, and 5'b11110 gives the largest multiple of three.
- R6: Every other pattern code gives a count of zero, so the result equals the operand.
- R7: Each lane result is the lane operand plus count times multiplier, taken modulo 2 to the power of the lane size. No carry passes between lanes.
- R8: An operation is accepted on a clock edge where in_valid_i and in_ready_o are both high. out_valid_o is high after that edge. in_ready_o is high exactly when the output register is empty or is being drained in that cycle.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and result_o keeps its value.
- R10: While rst_ni is low, out_valid_o is low and result_o is zero, and in_ready_o is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation request |
| in_ready_o | output | 1 | Block can accept an operation |
| pattern_i | input | 5 | Count pattern code |
| mult_i | input | 4 | Multiplier field (multiplier is this plus one) |
| esize_i | input | 2 | Lane size select: 0 = 16, 1 = 32, 2 or 3 = 64 bits |
| operand_i | input | VLEN | Source vector |
| out_valid_o | output | 1 | Result register holds a result |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | VLEN | Incremented vector |

## Verification
Two events can fall in the same cycle: a new operation is accepted while the previous result drains. When that happens, the output register must be reloaded rather than cleared. The bench drives operations back to back while out_ready_i follows a repeating pattern with stalls. This makes accept-while-draining, accept-blocked-by-stall and stall-hold cycles all occur. A scoreboard queue of results computed in the bench is compared with every drained result, so a dropped, duplicated or stale result shows up as a mismatch. Stall cycles are also checked for a result that does not change.

// File: rtl/vinc_pkg.sv
package vinc_pkg;

  typedef enum logic [1:0] {
    ES_H   = 2'd0,
    ES_W   = 2'd1,
    ES_D   = 2'd2,
    ES_RSV = 2'd3
  } esize_e;

  localparam logic [4:0] PAT_POW2 = 5'h00;
  localparam logic [4:0] PAT_MUL4 = 5'h1D;
  localparam logic [4:0] PAT_MUL3 = 5'h1E;
  localparam logic [4:0] PAT_ALL  = 5'h1F;

  function automatic int floor_pow2(int n);
    int p;
    p = 0;
    for (int i = 0; i < 16; i++) begin
      if ((32'sd1 <<< i) <= n) p = 32'sd1 <<< i;
    end
    return p;
  endfunction

  // fixed-count request, 0 when the code is not a fixed-count code
  function automatic int fixed_req(logic [4:0] pat);
    int p;
    p = int'(pat);
    if (p >= 1 && p <= 8) return p;
    if (p >= 9 && p <= 13) return 32'sd16 <<< (p - 9);
    return 0;
  endfunction

endpackage

// File: rtl/vinc_count_dec.sv
module vinc_count_dec
  import vinc_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int CNT_W = $clog2(VLEN / 16 + 1)
) (
  input  logic [4:0]       pattern_i,
  input  logic [1:0]       esize_i,
  output logic [CNT_W-1:0] count_o
);

  localparam int L16 = VLEN / 16;
  localparam int L32 = VLEN / 32;
  localparam int L64 = VLEN / 64;

  always_comb begin
    int lanes;
    int req;
    int c;
    case (esize_i)
      ES_H:    lanes = L16;
      ES_W:    lanes = L32;
      default: lanes = L64;
    endcase
    req = fixed_req(pattern_i);
    c   = 0;
    if (pattern_i == PAT_POW2) begin
      c = floor_pow2(lanes);
    end else if (req != 0) begin
      c = (req <= lanes) ? req : 0;
    end else begin
      case (pattern_i)
        PAT_MUL4: c = lanes - (lanes % 4);
        PAT_MUL3: c = lanes - (lanes % 3);
        PAT_ALL:  c = lanes;
        default:  c = 0;
      endcase
    end
    count_o = CNT_W'(c);
  end

endmodule

// File: rtl/vinc_addend.sv
module vinc_addend
  import vinc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [3:0]       mult_i,
  input  logic [1:0]       esize_i,
  output logic [63:0]      addend_o
);

  localparam int PW = CNT_W + 5;

  logic [PW-1:0] prod;
  logic [63:0]   wide;

  // one multiply, shared by every lane
  assign prod = PW'(count_i) * PW'({1'b0, mult_i} + 5'd1);
  assign wide = 64'(prod);

  always_comb begin
    case (esize_i)
      ES_H:    addend_o = {48'd0, wide[15:0]};
      ES_W:    addend_o = {32'd0, wide[31:0]};
      default: addend_o = wide;
    endcase
  end

endmodule

// File: rtl/vinc_lane_add.sv
module vinc_lane_add #(
  parameter int VLEN = 256,
  parameter int EW   = 16
) (
  input  logic [VLEN-1:0] vec_i,
  input  logic [EW-1:0]   addend_i,
  output logic [VLEN-1:0] sum_o
);

  localparam int NLANE = VLEN / EW;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign sum_o[i*EW +: EW] = vec_i[i*EW +: EW] + addend_i;
  end

endmodule

// File: rtl/vinc_top.sv
module vinc_top
  import vinc_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [4:0]      pattern_i,
  input  logic [3:0]      mult_i,
  input  logic [1:0]      esize_i,
  input  logic [VLEN-1:0] operand_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [VLEN-1:0] result_o
);

  localparam int CNT_W = $clog2(VLEN / 16 + 1);
  localparam int NSZ   = 3;

  logic [CNT_W-1:0] count;
  logic [63:0]      addend;
  logic [VLEN-1:0]  sums [NSZ];
  logic [VLEN-1:0]  next_res;
  logic [VLEN-1:0]  res_q;
  logic             valid_q;
  logic             accept;

  vinc_count_dec #(.VLEN(VLEN), .CNT_W(CNT_W)) u_count (
    .pattern_i (pattern_i),
    .esize_i   (esize_i),
    .count_o   (count)
  );

  vinc_addend #(.CNT_W(CNT_W)) u_addend (
    .count_i  (count),
    .mult_i   (mult_i),
    .esize_i  (esize_i),
    .addend_o (addend)
  );

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int EW = 16 << k;
    vinc_lane_add #(.VLEN(VLEN), .EW(EW)) u_add (
      .vec_i    (operand_i),
      .addend_i (addend[EW-1:0]),
      .sum_o    (sums[k])
    );
  end

  always_comb begin
    case (esize_i)
      ES_H:    next_res = sums[0];
      ES_W:    next_res = sums[1];
      default: next_res = sums[2];
    endcase
  end

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      res_q   <= next_res;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign result_o    = res_q;

endmodule

// File: rtl/vinc_top_chk.sv
module vinc_top_chk #(
  parameter int VLEN = 256
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [4:0]      pattern_i,
  input logic [3:0]      mult_i,
  input logic [1:0]      esize_i,
  input logic [VLEN-1:0] operand_i,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [VLEN-1:0] result_o
);

  logic acc;
  logic unalloc;
  logic too_big;
  int   lanes;

  assign acc     = in_valid_i && in_ready_o;
  assign unalloc = (pattern_i > 5'd13) && (pattern_i < 5'd29);
  assign lanes   = (esize_i == 2'd0) ? VLEN / 16 : (esize_i == 2'd1) ? VLEN / 32 : VLEN / 64;
  assign too_big = (vinc_pkg::fixed_req(pattern_i) > lanes);

  // R8
  accept_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  // R8
  stall_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (out_valid_o && !out_ready_i));

  // R9
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o)));

  // R6
  unalloc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && unalloc) |=> (result_o == $past(operand_i)));

  // R4
  oversize_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && too_big) |=> (result_o == $past(operand_i)));

  // R10
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && result_o == '0));

  // R2
  mult_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> !$isunknown(mult_i));

endmodule

bind vinc_top vinc_top_chk #(.VLEN(VLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .pattern_i   (pattern_i),
  .mult_i      (mult_i),
  .esize_i     (esize_i),
  .operand_i   (operand_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .result_o    (result_o)
);

// File: tb/tb_vinc_top.sv
module tb_vinc_top;

  localparam int VLEN = 256;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [4:0]      pattern_i = '0;
  logic [3:0]      mult_i = '0;
  logic [1:0]      esize_i = '0;
  logic [VLEN-1:0] operand_i = '0;
  logic            out_valid_o;
  logic            out_ready_i = 1'b1;
  logic [VLEN-1:0] result_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit stall_on = 1'b0;
  bit done = 1'b0;

  logic [VLEN-1:0] exp_q [$];
  string           tag_q [$];

  always #2.5 clk = ~clk;

  vinc_top #(.VLEN(VLEN)) dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .in_valid_i (in_valid_i), .in_ready_o (in_ready_o),
    .pattern_i (pattern_i), .mult_i (mult_i), .esize_i (esize_i),
    .operand_i (operand_i),
    .out_valid_o (out_valid_o), .out_ready_i (out_ready_i),
    .result_o (result_o)
  );

  function automatic int ref_lanes(logic [1:0] es);
    if (es == 2'd0) return VLEN / 16;
    if (es == 2'd1) return VLEN / 32;
    return VLEN / 64;
  endfunction

  function automatic int ref_count(logic [4:0] pat, logic [1:0] es);
    int n, r, p;
    n = ref_lanes(es);
    p = int'(pat);
    if (p == 0) begin
      r = 1;
      while (r * 2 <= n) r = r * 2;
      return r;
    end
    if (p >= 1 && p <= 8) return (p <= n) ? p : 0;
    if (p >= 9 && p <= 13) begin
      r = 16 * (1 << (p - 9));
      return (r <= n) ? r : 0;
    end
    if (p == 29) return (n / 4) * 4;
    if (p == 30) return (n / 3) * 3;
    if (p == 31) return n;
    return 0;
  endfunction

  function automatic logic [VLEN-1:0] ref_result(logic [VLEN-1:0] v, logic [4:0] pat,
                                                 logic [3:0] m, logic [1:0] es);
    logic [VLEN-1:0] o;
    logic [63:0] add, lane;
    int ew;
    ew  = (es == 2'd0) ? 16 : (es == 2'd1) ? 32 : 64;
    add = 64'(ref_count(pat, es)) * 64'(int'(m) + 1);
    o   = '0;
    for (int i = 0; i < VLEN / ew; i++) begin
      lane = 64'(v >> (i * ew)) + add;
      for (int b = 0; b < ew; b++) o[i*ew + b] = lane[b];
    end
    return o;
  endfunction

  function automatic string tag_of(logic [4:0] pat);
    if (pat == 5'd0) return "R3 (R1 R2 R7)";
    if (pat <= 5'd13) return "R4 (R1 R2 R7)";
    if (pat >= 5'd29) return "R5 (R1 R2 R7)";
    return "R6";
  endfunction

  task automatic check(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [VLEN-1:0] v, logic [4:0] pat, logic [3:0] m,
                      logic [1:0] es, string tag);
    in_valid_i = 1'b1;
    operand_i  = v;
    pattern_i  = pat;
    mult_i     = m;
    esize_i    = es;
    while (!in_ready_o) @(negedge clk);
    exp_q.push_back(ref_result(v, pat, m, es));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid_i = 1'b0;
    // R8: result register loaded one edge after acceptance
    check(out_valid_o == 1'b1, "R8", VLEN'(out_valid_o), VLEN'(1));
  endtask

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // backpressure, changed just after the active edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready_i = stall_on ? ((cyc % 7) != 2 && (cyc % 7) != 3) : 1'b1;
  end

  // monitor / scoreboard
  logic [VLEN-1:0] held;
  bit              was_stalled = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (was_stalled) begin
        // R9: stalled result stays put
        check(out_valid_o && result_o == held, "R9", result_o, held);
      end
      was_stalled = out_valid_o && !out_ready_i;
      held        = result_o;
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", result_o, '0);
        end else begin
          logic [VLEN-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(result_o == e, t, result_o, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid_o == 1'b0, "R10 valid", VLEN'(out_valid_o), '0);
    check(result_o == '0, "R10 result", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready_o == 1'b1, "R10 ready", VLEN'(in_ready_o), VLEN'(1));

    // R7: wrap per lane, no carry into neighbour
    send({VLEN{1'b1}}, 5'h1F, 4'hF, 2'd0, "R7 wrap16");
    send({VLEN{1'b1}}, 5'h1F, 4'hF, 2'd1, "R7 wrap32");
    send({VLEN{1'b1}}, 5'h1F, 4'hF, 2'd2, "R7 wrap64");
    // R1: esize code 3 behaves as 64-bit lanes
    send(rand_vec(), 5'h1F, 4'h3, 2'd3, "R1 esize3");
    // R2: multiplier bounds
    send('0, 5'h01, 4'h0, 2'd0, "R2 mult1");
    send('0, 5'h01, 4'hF, 2'd0, "R2 mult16");

    // full sweep, back to back, no stall
    for (int es = 0; es < 3; es++)
      for (int p = 0; p < 32; p++)
        for (int m = 0; m < 16; m += 5)
          send(rand_vec(), 5'(p), 4'(m), 2'(es), tag_of(5'(p)));

    // same sweep with every multiplier, under backpressure (R8 R9)
    stall_on = 1'b1;
    for (int es = 0; es < 4; es++)
      for (int p = 0; p < 32; p++)
        for (int m = 0; m < 16; m++)
          send(rand_vec(), 5'(p), 4'(m), 2'(es), tag_of(5'(p)));
    stall_on = 1'b0;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R8 drained", VLEN'(exp_q.size()), '0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 act=%0d exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule